// File: doc/BRIEF.md
# Single-Buffer E-Paper Frame Sequencer

This block loads one rectangular frame into an e-paper controller that holds two image RAMs: a "new" RAM and a "previous" RAM. The controller compares the two RAMs when it runs a differential refresh. The host keeps only one framebuffer. The previous frame is kept in the panel's second RAM, so that RAM is re-synchronised with the frame just shown at the end of every request. The sequencer reads the framebuffer through a byte-address port with a one-cycle read latency. It emits a stream of command and data bytes, and it watches the panel's busy line while a refresh runs.

A request carries a window (x, y, width, height in pixels), a refresh kind (fast or full/half) and the update-sequence byte for the refresh. Typical sequence bytes are 0xFC for a partial refresh and 0xF7 for a normal full refresh. Before each RAM write the block programs the RAM window:
- X counts upward.
- Y counts downward from a bottom-up reversed origin.

Back-pressure rules:
- The request side is a valid/ready pair. `req_ready` is high only while the sequencer is idle and the panel is not busy.
- The byte stream is a valid/ready pair. A byte and its command flag stay fixed while `out_valid` is high and `out_ready` is low.
- A byte transfers on each clock edge where both `out_valid` and `out_ready` are high.

Top module: `epd_frame_seq`

## Requirements
- R1: After reset `out_valid`, `done` and `err` are low, and `req_ready` is high while `panel_busy` is low.
- R2: `req_ready` is low while a request is in progress or `panel_busy` is high. No request is taken in that time.
- R3: A request is rejected if any of these holds: x or width is not a multiple of 8, width or height is zero, x+width exceeds 800, or y+height exceeds 480. A rejected request raises `err` for exactly one cycle, in the cycle after acceptance, and emits no byte.
- R4: Each window programming emits 18 bytes, listed here as flag/byte where C is a command (`out_is_cmd`=1) and D is data, with 16-bit values sent low byte first:
  - C 0x11, D 0x01
  - C 0x44, D x(2 bytes), D (x+w-1)(2 bytes)
  - C 0x45, D ystart(2 bytes), D yend(2 bytes)
  - C 0x4E, D x(2 bytes)
  - C 0x4F, D ystart(2 bytes)
- R5: With yr = 480 - y - h, ystart is yr + h - 1 and yend is yr.
- R6: A RAM write is a command (0x24 for the new RAM, 0x26 for the previous RAM) followed by (w/8)*h data bytes. The bytes are read row by row from framebuffer addresses (y+r)*100 + x/8 + c, where r is the row and c is the byte column. Framebuffer bits use 1 for white and 0 for black.
- R7: A fast request (`req_full`=0) runs in this order: window, new-RAM write, refresh, window, previous-RAM write.
- R8: A full request (`req_full`=1) runs in this order: window, new-RAM write, window, previous-RAM write, refresh, window, previous-RAM write.
- R9: A refresh emits C 0x22, then D `req_seq`, then C 0x20. No further byte is emitted until a fixed settle time has passed and `panel_busy` is low.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_is_cmd` hold their values.
- R11: `done` is high for exactly one cycle, in the cycle right after the final byte of a request is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_full | input | 1 | 1 = full/half refresh, 0 = fast refresh |
| req_seq | input | 8 | Update-sequence byte for the refresh |
| req_x | input | 10 | Window X origin in pixels |
| req_y | input | 9 | Window Y origin in pixels |
| req_w | input | 10 | Window width in pixels |
| req_h | input | 9 | Window height in rows |
| fb_addr | output | 16 | Framebuffer byte address |
| fb_rdata | input | 8 | Framebuffer byte, valid one cycle after the address |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_is_cmd | output | 1 | 1 = command byte, 0 = data byte |
| out_byte | output | 8 | Stream byte |
| panel_busy | input | 1 | Panel busy, active high |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request is rejected |

## Verification
The hardest case to reach is a stall that lands while a framebuffer read is in flight: the sink drops ready just as the walker wraps to a new row, or on the last re-sync byte. In that case the fetched byte must survive the stall and `done` must still follow the true final transfer. The bench drives `out_ready` from a pseudo-random sequence on multi-row windows, so stalls fall on row wraps, window bytes and the final byte. A queue-based model checks every transfer, the hold rule and the `done` timing on every clock. A separate phase holds `panel_busy` high with a request pending to show that the request is not taken.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  typedef enum logic [1:0] {
    SEG_WIN = 2'd0,
    SEG_NEW = 2'd1,
    SEG_OLD = 2'd2,
    SEG_REF = 2'd3
  } seg_e;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_WIN     = 4'd1,
    ST_RCMD    = 4'd2,
    ST_DWAIT   = 4'd3,
    ST_DPUSH   = 4'd4,
    ST_RFSH    = 4'd5,
    ST_RDRAIN  = 4'd6,
    ST_RSETTLE = 4'd7,
    ST_RBUSY   = 4'd8,
    ST_FIN     = 4'd9
  } st_e;

  localparam logic [7:0] OP_ENTRY    = 8'h11;
  localparam logic [7:0] ENTRY_XUYD  = 8'h01;
  localparam logic [7:0] OP_XWIN     = 8'h44;
  localparam logic [7:0] OP_YWIN     = 8'h45;
  localparam logic [7:0] OP_XCNT     = 8'h4E;
  localparam logic [7:0] OP_YCNT     = 8'h4F;
  localparam logic [7:0] OP_RAM_NEW  = 8'h24;
  localparam logic [7:0] OP_RAM_OLD  = 8'h26;
  localparam logic [7:0] OP_UPD_SEQ  = 8'h22;
  localparam logic [7:0] OP_ACTIVATE = 8'h20;

  localparam logic [4:0] WIN_LAST_STEP = 5'd17;

  // Segment order for a request; the re-sync of the previous RAM is always last.
  function automatic seg_e plan_seg(input logic full, input logic [2:0] idx);
    seg_e s;
    s = SEG_WIN;
    if (full) begin
      case (idx)
        3'd1:    s = SEG_NEW;
        3'd3:    s = SEG_OLD;
        3'd4:    s = SEG_REF;
        3'd6:    s = SEG_OLD;
        default: s = SEG_WIN;
      endcase
    end else begin
      case (idx)
        3'd1:    s = SEG_NEW;
        3'd2:    s = SEG_REF;
        3'd4:    s = SEG_OLD;
        default: s = SEG_WIN;
      endcase
    end
    return s;
  endfunction

  function automatic logic [2:0] plan_last(input logic full);
    return full ? 3'd6 : 3'd4;
  endfunction

endpackage

// File: rtl/epd_geom.sv
module epd_geom #(
  parameter int PANEL_W = 800,
  parameter int PANEL_H = 480,
  parameter int XW      = 10,
  parameter int YW      = 9,
  parameter int AW      = 16,
  parameter int WBW     = 7
) (
  input  logic [XW-1:0]  x,
  input  logic [YW-1:0]  y,
  input  logic [XW-1:0]  w,
  input  logic [YW-1:0]  h,
  output logic           ok,
  output logic [15:0]    xs,
  output logic [15:0]    xe,
  output logic [15:0]    ys,
  output logic [15:0]    ye,
  output logic [AW-1:0]  base,
  output logic [WBW-1:0] ncols
);
  localparam int STRIDE = PANEL_W / 8;

  logic [XW:0]   xend;
  logic [YW:0]   yend;
  logic [15:0]   yrev;

  always_comb begin
    xend  = {1'b0, x} + {1'b0, w};
    yend  = {1'b0, y} + {1'b0, h};
    ok    = (x[2:0] == 3'd0) && (w[2:0] == 3'd0) && (w != '0) && (h != '0)
            && (32'(xend) <= PANEL_W) && (32'(yend) <= PANEL_H);
    yrev  = 16'(PANEL_H) - 16'(yend);
    xs    = 16'(x);
    xe    = 16'(xend) - 16'd1;
    ys    = yrev + 16'(h) - 16'd1;
    ye    = yrev;
    base  = AW'(y) * AW'(STRIDE) + AW'(x >> 3);
    ncols = WBW'(w >> 3);
  end
endmodule

// File: rtl/epd_win_script.sv
module epd_win_script
  import epd_seq_pkg::*;
(
  input  logic [4:0]  step,
  input  logic [15:0] xs,
  input  logic [15:0] xe,
  input  logic [15:0] ys,
  input  logic [15:0] ye,
  output logic        is_cmd,
  output logic [7:0]  data
);
  always_comb begin
    is_cmd = 1'b0;
    data   = 8'h00;
    case (step)
      5'd0:  begin is_cmd = 1'b1; data = OP_ENTRY; end
      5'd1:  data = ENTRY_XUYD;
      5'd2:  begin is_cmd = 1'b1; data = OP_XWIN; end
      5'd3:  data = xs[7:0];
      5'd4:  data = xs[15:8];
      5'd5:  data = xe[7:0];
      5'd6:  data = xe[15:8];
      5'd7:  begin is_cmd = 1'b1; data = OP_YWIN; end
      5'd8:  data = ys[7:0];
      5'd9:  data = ys[15:8];
      5'd10: data = ye[7:0];
      5'd11: data = ye[15:8];
      5'd12: begin is_cmd = 1'b1; data = OP_XCNT; end
      5'd13: data = xs[7:0];
      5'd14: data = xs[15:8];
      5'd15: begin is_cmd = 1'b1; data = OP_YCNT; end
      5'd16: data = ys[7:0];
      5'd17: data = ys[15:8];
      default: begin is_cmd = 1'b0; data = 8'h00; end
    endcase
  end
endmodule

// File: rtl/epd_fb_walker.sv
module epd_fb_walker #(
  parameter int AW     = 16,
  parameter int STRIDE = 100,
  parameter int CW     = 7,
  parameter int RW     = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] ncols,
  input  logic [RW-1:0] nrows,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [RW-1:0] ONE_R = RW'(1);

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic [AW-1:0] row_base_q;
  logic          row_end;

  always_comb begin
    row_end = (col_q == ncols - ONE_C);
    last    = row_end && (row_q == nrows - ONE_R);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q      <= '0;
      row_q      <= '0;
      row_base_q <= '0;
      addr       <= '0;
    end else if (start) begin
      col_q      <= '0;
      row_q      <= '0;
      row_base_q <= base;
      addr       <= base;
    end else if (adv) begin
      if (row_end) begin
        col_q      <= '0;
        row_q      <= row_q + ONE_R;
        row_base_q <= row_base_q + AW'(STRIDE);
        addr       <= row_base_q + AW'(STRIDE);
      end else begin
        col_q <= col_q + ONE_C;
        addr  <= addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/epd_frame_seq.sv
module epd_frame_seq
  import epd_seq_pkg::*;
#(
  parameter int PANEL_W = 800,
  parameter int PANEL_H = 480,
  parameter int SETTLE  = 4,
  localparam int XW     = $clog2(PANEL_W + 1),
  localparam int YW     = $clog2(PANEL_H + 1),
  localparam int STRIDE = PANEL_W / 8,
  localparam int AW     = $clog2(STRIDE * PANEL_H),
  localparam int WBW    = XW - 3,
  localparam int SCW    = $clog2(SETTLE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_full,
  input  logic [7:0]    req_seq,
  input  logic [XW-1:0] req_x,
  input  logic [YW-1:0] req_y,
  input  logic [XW-1:0] req_w,
  input  logic [YW-1:0] req_h,
  output logic [AW-1:0] fb_addr,
  input  logic [7:0]    fb_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_is_cmd,
  output logic [7:0]    out_byte,
  input  logic          panel_busy,
  output logic          done,
  output logic          err
);
  st_e            state_q;
  logic [2:0]     seg_idx_q;
  logic [4:0]     step_q;
  logic [SCW-1:0] settle_q;
  logic           full_q;
  logic [7:0]     seq_q;
  logic [15:0]    xs_q, xe_q, ys_q, ye_q;
  logic [AW-1:0]  base_q;
  logic [WBW-1:0] ncol_q;
  logic [YW-1:0]  nrow_q;

  logic           out_valid_q, out_cmd_q, done_q, err_q;
  logic [7:0]     out_byte_q;

  logic           g_ok;
  logic [15:0]    g_xs, g_xe, g_ys, g_ye;
  logic [AW-1:0]  g_base;
  logic [WBW-1:0] g_ncols;

  logic           ws_cmd;
  logic [7:0]     ws_byte;
  logic           wk_start, wk_adv, wk_last;

  logic           slot_free, ld, ld_cmd, seg_end;
  logic [7:0]     ld_byte;
  seg_e           cur_seg, nxt_seg;
  st_e            nxt_first;

  epd_geom #(
    .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .XW(XW), .YW(YW), .AW(AW), .WBW(WBW)
  ) u_geom (
    .x(req_x), .y(req_y), .w(req_w), .h(req_h),
    .ok(g_ok), .xs(g_xs), .xe(g_xe), .ys(g_ys), .ye(g_ye),
    .base(g_base), .ncols(g_ncols)
  );

  epd_win_script u_script (
    .step(step_q), .xs(xs_q), .xe(xe_q), .ys(ys_q), .ye(ye_q),
    .is_cmd(ws_cmd), .data(ws_byte)
  );

  epd_fb_walker #(
    .AW(AW), .STRIDE(STRIDE), .CW(WBW), .RW(YW)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .start(wk_start), .adv(wk_adv),
    .base(base_q), .ncols(ncol_q), .nrows(nrow_q),
    .addr(fb_addr), .last(wk_last)
  );

  assign req_ready  = (state_q == ST_IDLE) && !panel_busy;
  assign out_valid  = out_valid_q;
  assign out_is_cmd = out_cmd_q;
  assign out_byte   = out_byte_q;
  assign done       = done_q;
  assign err        = err_q;

  always_comb begin
    cur_seg   = plan_seg(full_q, seg_idx_q);
    nxt_seg   = plan_seg(full_q, seg_idx_q + 3'd1);
    case (nxt_seg)
      SEG_WIN: nxt_first = ST_WIN;
      SEG_REF: nxt_first = ST_RFSH;
      default: nxt_first = ST_RCMD;
    endcase
    if (seg_idx_q == plan_last(full_q)) nxt_first = ST_FIN;
  end

  // Byte selection: what would be loaded into the output slot this cycle.
  always_comb begin
    slot_free = !out_valid_q || out_ready;
    ld        = 1'b0;
    ld_cmd    = 1'b0;
    ld_byte   = 8'h00;
    wk_start  = 1'b0;
    wk_adv    = 1'b0;
    seg_end   = 1'b0;
    case (state_q)
      ST_WIN: if (slot_free) begin
        ld      = 1'b1;
        ld_cmd  = ws_cmd;
        ld_byte = ws_byte;
        seg_end = (step_q == WIN_LAST_STEP);
      end
      ST_RCMD: if (slot_free) begin
        ld       = 1'b1;
        ld_cmd   = 1'b1;
        ld_byte  = (cur_seg == SEG_NEW) ? OP_RAM_NEW : OP_RAM_OLD;
        wk_start = 1'b1;
      end
      ST_DPUSH: if (slot_free) begin
        ld      = 1'b1;
        ld_byte = fb_rdata;
        wk_adv  = 1'b1;
        seg_end = wk_last;
      end
      ST_RFSH: if (slot_free) begin
        ld = 1'b1;
        case (step_q)
          5'd0:    begin ld_cmd = 1'b1; ld_byte = OP_UPD_SEQ; end
          5'd1:    ld_byte = seq_q;
          default: begin ld_cmd = 1'b1; ld_byte = OP_ACTIVATE; end
        endcase
      end
      ST_RBUSY: seg_end = !panel_busy;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_cmd_q   <= 1'b0;
      out_byte_q  <= 8'h00;
    end else if (ld) begin
      out_valid_q <= 1'b1;
      out_cmd_q   <= ld_cmd;
      out_byte_q  <= ld_byte;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      seg_idx_q <= '0;
      step_q    <= '0;
      settle_q  <= '0;
      full_q    <= 1'b0;
      seq_q     <= 8'h00;
      xs_q      <= '0;
      xe_q      <= '0;
      ys_q      <= '0;
      ye_q      <= '0;
      base_q    <= '0;
      ncol_q    <= '0;
      nrow_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid && req_ready) begin
          if (g_ok) begin
            full_q    <= req_full;
            seq_q     <= req_seq;
            xs_q      <= g_xs;
            xe_q      <= g_xe;
            ys_q      <= g_ys;
            ye_q      <= g_ye;
            base_q    <= g_base;
            ncol_q    <= g_ncols;
            nrow_q    <= req_h;
            seg_idx_q <= '0;
            step_q    <= '0;
            state_q   <= ST_WIN;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_WIN: if (ld) begin
          if (seg_end) begin
            seg_idx_q <= seg_idx_q + 3'd1;
            step_q    <= '0;
            state_q   <= nxt_first;
          end else begin
            step_q <= step_q + 5'd1;
          end
        end
        ST_RCMD:  if (ld) state_q <= ST_DWAIT;
        ST_DWAIT: state_q <= ST_DPUSH;
        ST_DPUSH: if (ld) begin
          if (seg_end) begin
            seg_idx_q <= seg_idx_q + 3'd1;
            step_q    <= '0;
            state_q   <= nxt_first;
          end else begin
            state_q <= ST_DWAIT;
          end
        end
        ST_RFSH: if (ld) begin
          if (step_q == 5'd2) state_q <= ST_RDRAIN;
          else                step_q  <= step_q + 5'd1;
        end
        ST_RDRAIN: if (slot_free) begin
          settle_q <= '0;
          state_q  <= ST_RSETTLE;
        end
        ST_RSETTLE: begin
          if (settle_q == SCW'(SETTLE - 1)) state_q <= ST_RBUSY;
          else                              settle_q <= settle_q + SCW'(1);
        end
        ST_RBUSY: if (seg_end) begin
          seg_idx_q <= seg_idx_q + 3'd1;
          step_q    <= '0;
          state_q   <= nxt_first;
        end
        ST_FIN: if (slot_free) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epd_frame_seq_chk.sv
module epd_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       panel_busy,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_is_cmd,
  input logic [7:0] out_byte,
  input logic       done,
  input logic       err
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_cmd)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_drained_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  p_err_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_err_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  p_no_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    panel_busy |-> !req_ready);

  p_pause_after_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_is_cmd && out_byte == 8'h20) |=> !out_valid);
endmodule

bind epd_frame_seq epd_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .panel_busy(panel_busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_is_cmd(out_is_cmd),
  .out_byte(out_byte), .done(done), .err(err)
);

// File: tb/epd_frame_seq_bench.sv
module epd_frame_seq_bench;
  localparam int BUSY_LEN = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_full = 1'b0;
  logic [7:0] req_seq = 8'h00;
  logic [9:0] req_x = '0;
  logic [8:0] req_y = '0;
  logic [9:0] req_w = '0;
  logic [8:0] req_h = '0;
  logic [15:0] fb_addr;
  logic [7:0] fb_rdata = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_is_cmd;
  logic [7:0] out_byte;
  logic       panel_busy = 1'b0;
  logic       done, err;

  int ncmp = 0, nfail = 0, cyc = 0;
  bit active = 0, exp_done = 0, exp_err = 0, busy_kick = 0, ext_busy = 0;
  bit prev_stall = 0, mon_en = 0, finished = 0;
  logic [8:0] prev_word = '0;
  int rmode = 0, bcnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  epd_frame_seq u_epd_frame_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_full(req_full), .req_seq(req_seq), .req_x(req_x), .req_y(req_y),
    .req_w(req_w), .req_h(req_h), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_cmd(out_is_cmd),
    .out_byte(out_byte), .panel_busy(panel_busy), .done(done), .err(err)
  );

  function automatic logic [7:0] fbv(int a);
    return 8'((a * 29) ^ (a >> 5) ^ 8'h3C);
  endfunction

  always @(posedge clk) fb_rdata <= fbv(int'(fb_addr));

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (rmode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
    if (busy_kick) begin bcnt = BUSY_LEN; busy_kick = 0; end
    else if (bcnt > 0) bcnt = bcnt - 1;
    panel_busy = (bcnt > 0) || ext_busy;
  end

  task automatic check(bit ok, string what, int act, int expv);
    ncmp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic push(bit c, logic [7:0] b, string t);
    exp_q.push_back({c, b});
    tag_q.push_back(t);
  endtask

  task automatic push_win(int x, int y, int w, int h);
    int yr, ys, xe;
    yr = 480 - y - h; ys = yr + h - 1; xe = x + w - 1;
    push(1, 8'h11, "R4 entry"); push(0, 8'h01, "R4 entry");
    push(1, 8'h44, "R4 xwin");
    push(0, 8'(x), "R4 xs"); push(0, 8'(x >> 8), "R4 xs");
    push(0, 8'(xe), "R4 xe"); push(0, 8'(xe >> 8), "R4 xe");
    push(1, 8'h45, "R5 ywin");
    push(0, 8'(ys), "R5 ys"); push(0, 8'(ys >> 8), "R5 ys");
    push(0, 8'(yr), "R5 ye"); push(0, 8'(yr >> 8), "R5 ye");
    push(1, 8'h4E, "R4 xcnt"); push(0, 8'(x), "R4 xcnt"); push(0, 8'(x >> 8), "R4 xcnt");
    push(1, 8'h4F, "R5 ycnt"); push(0, 8'(ys), "R5 ycnt"); push(0, 8'(ys >> 8), "R5 ycnt");
  endtask

  task automatic push_ram(logic [7:0] op, int x, int y, int w, int h, string t);
    push(1, op, t);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w / 8; c++)
        push(0, fbv((y + r) * 100 + x / 8 + c), "R6 payload");
  endtask

  task automatic push_ref(logic [7:0] s);
    push(1, 8'h22, "R9 seq cmd"); push(0, s, "R9 seq byte"); push(1, 8'h20, "R9 go");
  endtask

  task automatic build(bit full, logic [7:0] s, int x, int y, int w, int h);
    if (full) begin
      push_win(x, y, w, h); push_ram(8'h24, x, y, w, h, "R8 new");
      push_win(x, y, w, h); push_ram(8'h26, x, y, w, h, "R8 old");
      push_ref(s);
      push_win(x, y, w, h); push_ram(8'h26, x, y, w, h, "R8 resync");
    end else begin
      push_win(x, y, w, h); push_ram(8'h24, x, y, w, h, "R7 new");
      push_ref(s);
      push_win(x, y, w, h); push_ram(8'h26, x, y, w, h, "R7 resync");
    end
  endtask

  function automatic bit geom_ok(int x, int y, int w, int h);
    return (x % 8 == 0) && (w % 8 == 0) && (w > 0) && (h > 0) && (x + w <= 800) && (y + h <= 480);
  endfunction

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      logic [8:0] ew;
      string t;
      check(done === exp_done, "R11 done", done, exp_done);
      check(err === exp_err, "R3 err", err, exp_err);
      check(req_ready === (!active && !panel_busy), "R2 req_ready", req_ready, !active && !panel_busy);
      if (prev_stall)
        check(out_valid === 1'b1 && {out_is_cmd, out_byte} === prev_word, "R10 hold",
              {out_valid, out_is_cmd, out_byte}, {1'b1, prev_word});
      exp_done = 0; exp_err = 0;
      prev_stall = out_valid && !out_ready;
      prev_word = {out_is_cmd, out_byte};
      if (out_valid && out_ready) begin
        check(!panel_busy, "R9 byte while busy", panel_busy, 0);
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected byte", {out_is_cmd, out_byte}, 0);
        end else begin
          ew = exp_q.pop_front(); t = tag_q.pop_front();
          check({out_is_cmd, out_byte} === ew, t, {out_is_cmd, out_byte}, ew);
          if (exp_q.size() == 0 && active) begin exp_done = 1; active = 0; end
        end
        if (out_is_cmd && out_byte == 8'h20) busy_kick = 1;
      end
      if (req_valid && req_ready) begin
        if (geom_ok(req_x, req_y, req_w, req_h)) begin
          active = 1;
          build(req_full, req_seq, req_x, req_y, req_w, req_h);
        end else exp_err = 1;
      end
    end
  end

  task automatic report();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      nfail++;
      $display("FAIL watchdog expired: actual=hung expected=complete");
      report();
    end
  end

  task automatic do_req(bit full, logic [7:0] s, int x, int y, int w, int h, int mode);
    rmode = mode;
    @(posedge clk); #1;
    req_full = full; req_seq = s;
    req_x = 10'(x); req_y = 9'(y); req_w = 10'(w); req_h = 9'(h);
    req_valid = 1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
    repeat (3) @(negedge clk);
    while (active || panel_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    check(done === 1'b0, "R1 done", done, 0);
    check(err === 1'b0, "R1 err", err, 0);
    check(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
    mon_en = 1;

    do_req(0, 8'hFC, 8, 16, 16, 3, 0);    // R7 fast, free-flowing sink
    do_req(1, 8'hF7, 0, 0, 24, 2, 1);     // R8 full, back-pressure
    do_req(0, 8'hFC, 784, 478, 16, 2, 1); // R5 bottom edge, yr = 0
    do_req(1, 8'hF7, 256, 100, 64, 5, 1); // R4 X high byte nonzero
    do_req(0, 8'hFC, 4, 0, 16, 2, 0);     // R3 misaligned x
    do_req(0, 8'hFC, 8, 0, 12, 2, 0);     // R3 misaligned width
    do_req(0, 8'hFC, 8, 0, 16, 0, 0);     // R3 zero height
    do_req(0, 8'hFC, 0, 470, 16, 16, 0);  // R3 beyond bottom
    do_req(0, 8'hFC, 792, 0, 16, 1, 0);   // R3 beyond right edge

    // R2: request held while the panel reports busy is not taken
    @(posedge clk); #1 ext_busy = 1;
    repeat (2) @(posedge clk);
    #1;
    req_full = 0; req_seq = 8'hFC; req_x = 10'd16; req_y = 9'd8; req_w = 10'd8; req_h = 9'd1;
    req_valid = 1;
    repeat (6) @(posedge clk);
    #1 req_valid = 0;
    @(negedge clk);
    check(exp_q.size() == 0 && !active, "R2 taken while busy", active, 0);
    @(posedge clk); #1 ext_busy = 0;
    repeat (3) @(negedge clk);

    do_req(0, 8'hFC, 0, 0, 8, 4, 1);      // R11 after busy release
    check(exp_q.size() == 0, "R7 stream drained", exp_q.size(), 0);
    report();
  end
endmodule